// File: doc/BRIEF.md
# Destination-Width Carry ALU

This block is the integer execution unit of a small microcontroller core. Each operation takes two sources that are already zero-extended to 32 bits, plus a code giving the width of the destination field: 8, 16 or 32 bits. The destination width truncates the stored result. It also chooses which bit of the 33-bit arithmetic result becomes the carry: bit 8, 16 or 32.

The unit holds one carry flag. Add-with-carry and subtract-with-borrow read it, and all six add/subtract operations write it. The other operations are logical, shift, unsigned min/max, bit set/clear and left-most bit detect, and they leave the flag alone.

Results and the flag are registered. When `valid_i` is high, both are written on the same clock edge. While `valid_i` is low, both hold their values.

The block has no state machine. It has a single operating condition: it executes when `valid_i` is high and holds otherwise.

Top module: `wca_alu`

## Requirements
- R1: Operation codes are ADD=0, ADDC=1, SUB=2, SUBB=3, RSUB=4, RSUBB=5, SHL=6, SHR=7, AND=8, OR=9, XOR=10, NOT=11, MIN=12, MAX=13, BCLR=14, BSET=15, LMBD=16. ADD stores the truncated value of a+b.
- R2: Width code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. For every operation, result bits at and above the selected width read 0.
- R3: ADD, SUB and RSUB set the carry to the bit of the 33-bit result that sits at the selected width (bit 8, 16 or 32).
- R4: ADDC computes a+b+carry. SUBB computes a-b-carry. A subtraction's carry is the raw two's-complement bit, so it reads 1 on a borrow.
- R5: RSUB computes b-a and RSUBB computes b-a-carry, with the same carry rule as R3.
- R6: SHL, SHR, BSET and BCLR use only b[4:0] as the shift amount or bit index. SHL gives a<<n, SHR gives a>>n, BSET gives a|(1<<n) and BCLR gives a&~(1<<n).
- R7: MIN and MAX compare a and b as unsigned 32-bit numbers.
- R8: LMBD scans a from the top bit of its source field downward, looking for a bit equal to b[0]. The source field width is set by `src_width_i`, using the same code as R2. LMBD returns the index of the first match, or 32 if no bit matches.
- R9: Operations 6 to 16 leave the carry flag unchanged.
- R10: Reset clears the result and the carry to 0. While `valid_i` is low, the result and the carry hold.
- R11: AND, OR and XOR give the bitwise combination of a and b. NOT gives ~a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Execute strobe |
| op_i | input | 5 | Operation code (R1) |
| dst_width_i | input | 2 | Destination width code |
| src_width_i | input | 2 | Source field width code for LMBD |
| src_a_i | input | 32 | First source, zero-extended |
| src_b_i | input | 32 | Second source, zero-extended |
| result_o | output | 32 | Registered truncated result |
| carry_o | output | 1 | Carry flag |

## Verification
The assertions assume that `op_i` holds a defined code from 0 to 16 whenever `valid_i` is high, and that the inputs are free of unknown values after reset. The stimulus draws operation codes only from that range. Idle cycles with `valid_i` low are mixed in with random garbage on the other inputs. All four width codes are used, including the aliased code 3, so the assertions that check truncation and carry hold see every width.

// File: rtl/wca_pkg.sv
package wca_pkg;
    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBB  = 5'd3,
        OP_RSUB  = 5'd4,
        OP_RSUBB = 5'd5,
        OP_SHL   = 5'd6,
        OP_SHR   = 5'd7,
        OP_AND   = 5'd8,
        OP_OR    = 5'd9,
        OP_XOR   = 5'd10,
        OP_NOT   = 5'd11,
        OP_MIN   = 5'd12,
        OP_MAX   = 5'd13,
        OP_BCLR  = 5'd14,
        OP_BSET  = 5'd15,
        OP_LMBD  = 5'd16
    } wca_op_e;

    localparam int unsigned FIELD_BYTE = 8;
    localparam int unsigned FIELD_HALF = 16;
    localparam int unsigned FIELD_WORD = 32;

    function automatic int unsigned field_len(input logic [1:0] code);
        case (code)
            2'd0:    return FIELD_BYTE;
            2'd1:    return FIELD_HALF;
            default: return FIELD_WORD;
        endcase
    endfunction

    function automatic logic op_updates_carry(input logic [4:0] op);
        return op <= 5'd5;
    endfunction
endpackage

// File: rtl/wca_arith.sv
module wca_arith
    import wca_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W:0]   raw
);
    localparam int unsigned EXT_W = DATA_W + 1;

    logic              reverse;
    logic              subtract;
    logic              use_cin;
    logic [EXT_W-1:0]  lhs;
    logic [EXT_W-1:0]  rhs;
    logic [EXT_W-1:0]  cext;

    always_comb begin
        reverse  = (op == OP_RSUB) || (op == OP_RSUBB);
        subtract = (op == OP_SUB) || (op == OP_SUBB) || reverse;
        use_cin  = (op == OP_ADDC) || (op == OP_SUBB) || (op == OP_RSUBB);
        lhs      = reverse ? {1'b0, b} : {1'b0, a};
        rhs      = reverse ? {1'b0, a} : {1'b0, b};
        cext     = {{DATA_W{1'b0}}, (use_cin & cin)};
        if (subtract) raw = lhs - rhs - cext;
        else          raw = lhs + rhs + cext;
    end
endmodule

// File: rtl/wca_bitops.sv
module wca_bitops
    import wca_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] onehot;

    always_comb begin
        idx    = b[IDX_W-1:0];
        onehot = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
        unique case (op)
            OP_SHL:  y = a << idx;
            OP_SHR:  y = a >> idx;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_MIN:  y = (b > a) ? a : b;
            OP_MAX:  y = (b > a) ? b : a;
            OP_BCLR: y = a & ~onehot;
            OP_BSET: y = a | onehot;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/wca_lmbd.sv
module wca_lmbd
    import wca_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]         a,
    input  logic                      want,
    input  logic [1:0]                field_code,
    output logic [$clog2(DATA_W):0]   index
);
    localparam int unsigned IDX_W = $clog2(DATA_W) + 1;

    int unsigned       flen;
    logic [DATA_W-1:0] hit;

    assign flen = field_len(field_code);

    for (genvar i = 0; i < DATA_W; i++) begin : g_hit
        assign hit[i] = (i < flen) && (a[i] == want);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        index = IDX_W'(DATA_W);
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!found && hit[i]) begin
                found = 1'b1;
                index = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wca_alu.sv
module wca_alu
    import wca_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [4:0]        op_i,
    input  logic [1:0]        dst_width_i,
    input  logic [1:0]        src_width_i,
    input  logic [31:0]       src_a_i,
    input  logic [31:0]       src_b_i,
    output logic [31:0]       result_o,
    output logic              carry_o
);
    localparam int unsigned IDX_W = $clog2(DATA_W) + 1;

    logic [DATA_W:0]   arith_raw;
    logic [DATA_W-1:0] bit_y;
    logic [IDX_W-1:0]  lead_idx;
    logic [DATA_W-1:0] full_res;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] trunc_res;
    logic              carry_next;
    int unsigned       dlen;
    logic [DATA_W-1:0] res_q;
    logic              carry_q;

    wca_arith #(.DATA_W(DATA_W)) u_arith (
        .op  (op_i),
        .a   (src_a_i),
        .b   (src_b_i),
        .cin (carry_q),
        .raw (arith_raw)
    );

    wca_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op (op_i),
        .a  (src_a_i),
        .b  (src_b_i),
        .y  (bit_y)
    );

    wca_lmbd #(.DATA_W(DATA_W)) u_lmbd (
        .a          (src_a_i),
        .want       (src_b_i[0]),
        .field_code (src_width_i),
        .index      (lead_idx)
    );

    always_comb begin
        dlen       = field_len(dst_width_i);
        keep_mask  = (dlen >= DATA_W) ? '1 : ((DATA_W'(1) << dlen) - DATA_W'(1));
        carry_next = arith_raw[dlen];
        if (op_updates_carry(op_i))  full_res = arith_raw[DATA_W-1:0];
        else if (op_i == OP_LMBD)    full_res = DATA_W'(lead_idx);
        else                         full_res = bit_y;
        trunc_res  = full_res & keep_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            carry_q <= 1'b0;
        end else if (valid_i) begin
            res_q <= trunc_res;
            if (op_updates_carry(op_i)) carry_q <= carry_next;
        end
    end

    assign result_o = res_q;
    assign carry_o  = carry_q;

    assert_trunc8_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dst_width_i == 2'd0) |=> (result_o[31:8] == 24'd0));

    assert_trunc16_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dst_width_i == 2'd1) |=> (result_o[31:16] == 16'd0));

    assert_carry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i > 5'd5) |=> $stable(carry_o));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i) |=> ($stable(result_o) && $stable(carry_o)));

    assert_lmbd_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 5'd16) |=> (result_o <= 32'd32));

    assert_add8_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 5'd0 && dst_width_i == 2'd0 && src_a_i < 32'd256 && src_b_i < 32'd256)
        |=> (carry_o == (({1'b0, $past(src_a_i[7:0])} + {1'b0, $past(src_b_i[7:0])}) > 9'd255)));
endmodule

// File: tb/wca_alu_tb.sv
module wca_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [1:0]  dst_width_i = '0;
    logic [1:0]  src_width_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [31:0] result_o;
    logic        carry_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_res = '0;
    logic        m_carry = 1'b0;

    always #5 clk = ~clk;

    wca_alu u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .dst_width_i(dst_width_i), .src_width_i(src_width_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i),
        .result_o(result_o), .carry_o(carry_o)
    );

    function automatic int wlen(input logic [1:0] c);
        return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 32;
    endfunction

    task automatic model(input logic [4:0] op, input logic [1:0] dw, input logic [1:0] sw,
                         input logic [31:0] a, input logic [31:0] b);
        logic [63:0] s;
        logic [63:0] mask;
        logic [63:0] v;
        int          w;
        int          n;
        logic        c;
        c    = m_carry;
        w    = wlen(dw);
        mask = (64'd1 << w) - 64'd1;
        n    = int'(b[4:0]);
        s    = 64'd0;
        case (op)
            5'd0:  s = {32'd0, a} + {32'd0, b};
            5'd1:  s = {32'd0, a} + {32'd0, b} + {63'd0, c};
            5'd2:  s = {32'd0, a} - {32'd0, b};
            5'd3:  s = {32'd0, a} - {32'd0, b} - {63'd0, c};
            5'd4:  s = {32'd0, b} - {32'd0, a};
            5'd5:  s = {32'd0, b} - {32'd0, a} - {63'd0, c};
            default: ;
        endcase
        if (op <= 5'd5) begin
            v = s;
            m_carry = s[w];
        end else begin
            case (op)
                5'd6:  v = {32'd0, a << n};
                5'd7:  v = {32'd0, a >> n};
                5'd8:  v = {32'd0, a & b};
                5'd9:  v = {32'd0, a | b};
                5'd10: v = {32'd0, a ^ b};
                5'd11: v = {32'd0, ~a};
                5'd12: v = (a < b) ? {32'd0, a} : {32'd0, b};
                5'd13: v = (a > b) ? {32'd0, a} : {32'd0, b};
                5'd14: v = {32'd0, a & ~(32'd1 << n)};
                5'd15: v = {32'd0, a | (32'd1 << n)};
                default: begin
                    v = 64'd32;
                    for (int i = wlen(sw) - 1; i >= 0; i--) begin
                        if (a[i] == b[0]) begin
                            v = 64'(i);
                            break;
                        end
                    end
                end
            endcase
        end
        m_res = 32'(v & mask);
    endtask

    task automatic check(input string tag);
        checks++;
        if (result_o !== m_res || carry_o !== m_carry) begin
            fails++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     tag, result_o, carry_o, m_res, m_carry);
        end
    endtask

    task automatic step(input logic v, input logic [4:0] op, input logic [1:0] dw,
                        input logic [1:0] sw, input logic [31:0] a, input logic [31:0] b,
                        input string tag);
        @(negedge clk);
        valid_i = v; op_i = op; dst_width_i = dw; src_width_i = sw;
        src_a_i = a; src_b_i = b;
        if (v) model(op, dw, sw, a, b);
        @(negedge clk);
        valid_i = 1'b0;
        check(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: result=%h carry=%b expected completion", result_o, carry_o);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset");
        rst_n = 1'b1;
        step(1, 5'd0, 2'd0, 2'd0, 32'hFF, 32'h1, "R3 add8 wrap");
        step(1, 5'd0, 2'd1, 2'd0, 32'hFFFF, 32'h1, "R3 add16 wrap");
        step(1, 5'd0, 2'd2, 2'd0, 32'hFFFF_FFFF, 32'h1, "R3 add32 wrap");
        step(1, 5'd0, 2'd0, 2'd0, 32'h1234, 32'h0, "R2 R1 add8 trunc");
        step(1, 5'd0, 2'd3, 2'd0, 32'h8000_0000, 32'h8000_0000, "R2 code3 alias");
        step(1, 5'd1, 2'd2, 2'd0, 32'd5, 32'd6, "R4 addc");
        step(1, 5'd2, 2'd0, 2'd0, 32'd3, 32'd5, "R4 sub borrow");
        step(1, 5'd3, 2'd2, 2'd0, 32'd10, 32'd3, "R4 subb");
        step(1, 5'd4, 2'd2, 2'd0, 32'd3, 32'd10, "R5 rsub");
        step(1, 5'd4, 2'd1, 2'd0, 32'd10, 32'd3, "R5 rsub borrow");
        step(1, 5'd5, 2'd2, 2'd0, 32'd1, 32'd9, "R5 rsubb");
        step(1, 5'd2, 2'd0, 2'd0, 32'd0, 32'd1, "R4 set carry");
        step(1, 5'd8, 2'd2, 2'd0, 32'hF0F0, 32'h0FF0, "R9 R11 and holds carry");
        step(1, 5'd9, 2'd1, 2'd0, 32'hF0F0, 32'h0F0F, "R11 or");
        step(1, 5'd10, 2'd2, 2'd0, 32'hFF00, 32'h0FF0, "R11 xor");
        step(1, 5'd11, 2'd1, 2'd0, 32'h00FF, 32'h0, "R11 not16");
        step(1, 5'd6, 2'd2, 2'd0, 32'h1, 32'd33, "R6 shl mod32");
        step(1, 5'd7, 2'd2, 2'd0, 32'h8000_0000, 32'd63, "R6 shr mod32");
        step(1, 5'd15, 2'd2, 2'd0, 32'h0, 32'd37, "R6 bset mod32");
        step(1, 5'd14, 2'd2, 2'd0, 32'hFFFF_FFFF, 32'd32, "R6 bclr mod32");
        step(1, 5'd12, 2'd2, 2'd0, 32'h8000_0000, 32'h1, "R7 min unsigned");
        step(1, 5'd13, 2'd2, 2'd0, 32'h8000_0000, 32'h1, "R7 max unsigned");
        step(1, 5'd16, 2'd2, 2'd0, 32'hF0, 32'h1, "R8 lmbd8 one");
        step(1, 5'd16, 2'd2, 2'd2, 32'hF0, 32'h0, "R8 lmbd32 zero");
        step(1, 5'd16, 2'd2, 2'd1, 32'h0, 32'h1, "R8 lmbd none");
        step(1, 5'd16, 2'd0, 2'd1, 32'hFFFF, 32'h0, "R8 lmbd none w8");
        step(0, 5'd0, 2'd0, 2'd0, 32'hFF, 32'hFF, "R10 idle hold");
        for (int k = 0; k < 600; k++) begin
            logic v;
            logic [4:0] op;
            v  = ($urandom % 8) != 0;
            op = 5'($urandom % 17);
            step(v, op, 2'($urandom % 4), 2'($urandom % 4),
                 ($urandom % 4 == 0) ? 32'($urandom % 300) : $urandom,
                 ($urandom % 4 == 0) ? 32'($urandom % 300) : $urandom,
                 "R1 R3 R9 random");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule